// File: doc/BRIEF.md
# Sample-Locked Straight-Line Sequencer

This block is the control core of a fixed-program audio signal processor. A program of straight-line instructions lives in an external program memory. Each sample-ready strobe starts one pass through that program, at one instruction per clock. There are no loops and no branches. The pass ends on a jump-to-start instruction, which returns the program counter to zero and parks the core until the next strobe.

In the same cycle as the program address, the core presents a coefficient address and a circular delay-memory address. The opcode, the coefficient and the delayed sample can therefore be read in parallel from three separate memories. The coefficient pointer restarts at zero on every pass and steps through the parameter list in program order. The delay-memory base moves back by one location per pass inside a power-of-two ring, so a fixed instruction offset reaches the same age of sample on every pass.

A conditional skip instruction can cancel the instruction that follows it. A strobe that arrives while a pass is still running is recorded in a sticky overrun flag and starts the next pass as soon as the current one ends.

Top module: `seq_core`

## Requirements
- R1: After reset the core is idle (`busy_o` low) with program counter, coefficient address and delay base at zero, both enables low and `overrun_o` low. Until the first `smp_rdy_i`, `pc_o` stays 0 and `busy_o` stays low.
- R2: A `smp_rdy_i` seen at a clock edge while idle makes `busy_o` high from that edge with `pc_o` = 0. While running, `pc_o` rises by one per clock.
- R3: The instruction word is {opcode[DLY_AW+3:DLY_AW+1], coefficient flag [DLY_AW], offset [DLY_AW-1:0]}. Opcode 4 (end) returns `pc_o` to 0 and ends the pass at the next edge, so a pass with N instructions, end included, keeps `busy_o` high for exactly N cycles.
- R4: `coef_addr_o` is 0 on the first instruction of every pass. It rises by one after each instruction whose coefficient flag is set, and this includes instructions that are skipped.
- R5: `dly_addr_o` = (base + offset) mod 2^DLY_AW, presented combinationally in the same cycle as `pc_o` and `coef_addr_o`. The base is 0 on the first pass and drops by one at the end of every pass, wrapping from 0 to 2^DLY_AW-1.
- R6: Opcode 1 (multiply-accumulate) raises `acc_en_o` and opcode 2 (store) raises `wr_en_o`, each for that instruction's cycle only. Both stay low while idle and for opcodes 0, 3 and 4.
- R7: Opcode 3 (skip) with `cond_i` high cancels the next instruction: that instruction raises no enable, yet `pc_o` still advances past it.
- R8: A `smp_rdy_i` while running sets `overrun_o`, which stays set until reset. The running pass completes, and the next pass starts in the cycle right after the end instruction, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_rdy_i | input | 1 | Sample-ready strobe, one cycle wide |
| cond_i | input | 1 | Condition flag from the datapath, used by the skip opcode |
| instr_i | input | DLY_AW+4 | Instruction word read at `pc_o` |
| pc_o | output | log2(PROG_DEPTH) | Program memory address |
| coef_addr_o | output | COEF_AW | Coefficient memory address |
| dly_addr_o | output | DLY_AW | Delay memory address |
| acc_en_o | output | 1 | Multiply-accumulate enable |
| wr_en_o | output | 1 | Delay memory write enable |
| busy_o | output | 1 | High while a pass is running |
| overrun_o | output | 1 | Sticky flag: a sample arrived during a pass |

## Verification
Addresses and enables are combinational from the registered pointers and the instruction word, so they are due in the same cycle as the `pc_o` that fetched the instruction. The bench samples them at the falling edge of that cycle. A strobe driven at a falling edge takes effect at the next rising edge, so instruction 0 of the new pass is checked one falling edge after the strobe. A skip decided in cycle k shows as low enables in cycle k+1. An overrun strobe given in cycle k is due on `overrun_o` in cycle k+1. The bench walks the expected per-cycle table in lock step with these latencies, and derives the delay address from its own pass counter.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MAC   = 3'd1,
        OP_STORE = 3'd2,
        OP_SKIPC = 3'd3,
        OP_END   = 3'd4
    } op_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int DLY_AW = 4,
    localparam int IW = DLY_AW + 4
) (
    input  logic [IW-1:0]     instr,
    output op_e               op,
    output logic              coef_use,
    output logic [DLY_AW-1:0] ofs
);
    always_comb begin
        op       = op_e'(instr[IW-1:DLY_AW+1]);
        coef_use = instr[DLY_AW];
        ofs      = instr[DLY_AW-1:0];
    end
endmodule

// File: rtl/seq_dly_agen.sv
module seq_dly_agen #(
    parameter int DLY_AW = 4
) (
    input  logic [DLY_AW-1:0] base,
    input  logic [DLY_AW-1:0] ofs,
    output logic [DLY_AW-1:0] addr
);
    // ring length is 2**DLY_AW: modular wrap is the natural carry drop
    always_comb addr = base + ofs;
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int PROG_DEPTH = 256,
    parameter int COEF_AW    = 8,
    parameter int DLY_AW     = 4,
    localparam int PC_W      = $clog2(PROG_DEPTH),
    localparam int IW        = DLY_AW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_rdy_i,
    input  logic               cond_i,
    input  logic [IW-1:0]      instr_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [COEF_AW-1:0] coef_addr_o,
    output logic [DLY_AW-1:0]  dly_addr_o,
    output logic               acc_en_o,
    output logic               wr_en_o,
    output logic               busy_o,
    output logic               overrun_o
);
    generate
        if (PROG_DEPTH != 256 && PROG_DEPTH != 512) begin : g_bad_depth
            $error("PROG_DEPTH must be 256 or 512");
        end
    endgenerate

    typedef struct packed {
        logic               run;
        logic [PC_W-1:0]    pc;
        logic [COEF_AW-1:0] coef;
        logic [DLY_AW-1:0]  base;
        logic               skip;
        logic               pend;
        logic               ovr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    op_e               dec_op;
    logic              dec_coef;
    logic [DLY_AW-1:0] dec_ofs;
    logic              live;
    logic              end_exec;

    seq_decode #(.DLY_AW(DLY_AW)) u_dec (
        .instr    (instr_i),
        .op       (dec_op),
        .coef_use (dec_coef),
        .ofs      (dec_ofs)
    );

    seq_dly_agen #(.DLY_AW(DLY_AW)) u_agen (
        .base (st_q.base),
        .ofs  (dec_ofs),
        .addr (dly_addr_o)
    );

    assign live     = st_q.run & ~st_q.skip;
    assign end_exec = live & (dec_op == OP_END);

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (smp_rdy_i) st_d.run = 1'b1;
        end else begin
            if (smp_rdy_i) begin
                st_d.ovr  = 1'b1;
                st_d.pend = 1'b1;
            end
            st_d.skip = live & (dec_op == OP_SKIPC) & cond_i;
            if (end_exec) begin
                st_d.pc   = '0;
                st_d.coef = '0;
                st_d.base = st_q.base - DLY_AW'(1);
                st_d.run  = st_q.pend | smp_rdy_i;
                st_d.pend = 1'b0;
                st_d.skip = 1'b0;
            end else begin
                st_d.pc = st_q.pc + PC_W'(1);
                if (dec_coef) st_d.coef = st_q.coef + COEF_AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o        = st_q.pc;
    assign coef_addr_o = st_q.coef;
    assign busy_o      = st_q.run;
    assign overrun_o   = st_q.ovr;
    assign acc_en_o    = live & (dec_op == OP_MAC);
    assign wr_en_o     = live & (dec_op == OP_STORE);
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
    import seq_pkg::*;
#(
    parameter int PC_W    = 8,
    parameter int COEF_AW = 8,
    parameter int DLY_AW  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_rdy,
    input logic               cond,
    input op_e                op,
    input logic               skip,
    input logic               end_exec,
    input logic               pend,
    input logic [PC_W-1:0]    pc,
    input logic [COEF_AW-1:0] coef,
    input logic [DLY_AW-1:0]  base,
    input logic               acc_en,
    input logic               wr_en,
    input logic               busy,
    input logic               overrun
);
    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !end_exec |=> busy && pc == $past(pc) + PC_W'(1));

    // R3
    end_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && end_exec && !pend && !smp_rdy |=> !busy && pc == '0);

    // R4
    coef_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> coef == '0);

    // R5
    base_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_exec |=> base == $past(base) - DLY_AW'(1));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !acc_en && !wr_en);

    // R7
    skip_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !skip && op == OP_SKIPC && cond |=> !acc_en && !wr_en);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && smp_rdy |=> overrun);

    // R8
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_exec && (pend || smp_rdy) |=> busy && pc == '0);
endmodule

bind seq_core seq_core_chk #(
    .PC_W    (PC_W),
    .COEF_AW (COEF_AW),
    .DLY_AW  (DLY_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_rdy  (smp_rdy_i),
    .cond     (cond_i),
    .op       (dec_op),
    .skip     (st_q.skip),
    .end_exec (end_exec),
    .pend     (st_q.pend),
    .pc       (pc_o),
    .coef     (coef_addr_o),
    .base     (st_q.base),
    .acc_en   (acc_en_o),
    .wr_en    (wr_en_o),
    .busy     (busy_o),
    .overrun  (overrun_o)
);

// File: tb/test_seq_core.sv
module test_seq_core;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_AW     = 4;
    localparam int DLY_LEN    = 1 << DLY_AW;
    localparam int NINSTR     = 6;

    // per-cycle expectation: pc[21:14] coef[13:6] ofs[5:2] acc[1] wr[0]
    localparam logic [21:0] VEC [0:NINSTR-1] = '{
        {8'd0, 8'd0, 4'd0, 1'b1, 1'b0},
        {8'd1, 8'd1, 4'd3, 1'b1, 1'b0},
        {8'd2, 8'd2, 4'd0, 1'b0, 1'b0},
        {8'd3, 8'd2, 4'd5, 1'b1, 1'b0},
        {8'd4, 8'd3, 4'd0, 1'b0, 1'b1},
        {8'd5, 8'd3, 4'd0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_rdy = 1'b0;
    logic       cond = 1'b0;
    logic [7:0] instr;
    logic [7:0] pc;
    logic [7:0] coef;
    logic [3:0] dly;
    logic       acc_en, wr_en, busy, overrun;
    logic [7:0] prog [0:255];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign instr = prog[pc];

    seq_core i_seq_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_rdy_i   (smp_rdy),
        .cond_i      (cond),
        .instr_i     (instr),
        .pc_o        (pc),
        .coef_addr_o (coef),
        .dly_addr_o  (dly),
        .acc_en_o    (acc_en),
        .wr_en_o     (wr_en),
        .busy_o      (busy),
        .overrun_o   (overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse();
        smp_rdy = 1'b1;
        @(negedge clk);
        smp_rdy = 1'b0;
    endtask

    // walks one pass; p is the pass index, which fixes the delay base
    task automatic run_pass(input int p, input bit skip_at2, input bit late_rdy);
        int base_exp = (DLY_LEN - (p % DLY_LEN)) % DLY_LEN;
        for (int i = 0; i < NINSTR; i++) begin
            logic [21:0] v = VEC[i];
            int acc_exp = (skip_at2 && i == 3) ? 0 : int'(v[1]);
            int wr_exp  = (skip_at2 && i == 3) ? 0 : int'(v[0]);
            chk("R2 busy during pass", int'(busy), 1);
            chk("R2 pc sequence", int'(pc), int'(v[21:14]));
            chk("R4 coef address", int'(coef), int'(v[13:6]));
            chk("R5 delay address", int'(dly), (base_exp + int'(v[5:2])) % DLY_LEN);
            chk(skip_at2 ? "R7 acc cancelled" : "R6 acc enable", int'(acc_en), acc_exp);
            chk("R6 write enable", int'(wr_en), wr_exp);
            if (late_rdy && i == 3) chk("R8 overrun set", int'(overrun), 1);
            cond    = skip_at2 && i == 2;
            smp_rdy = late_rdy && i == 2;
            @(negedge clk);
            cond    = 1'b0;
            smp_rdy = 1'b0;
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) prog[a] = 8'h00;
        prog[0] = {3'd1, 1'b1, 4'd0};
        prog[1] = {3'd1, 1'b1, 4'd3};
        prog[2] = {3'd3, 1'b0, 4'd0};
        prog[3] = {3'd1, 1'b1, 4'd5};
        prog[4] = {3'd2, 1'b0, 4'd0};
        prog[5] = {3'd4, 1'b0, 4'd0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and idle hold
        chk("R1 busy", int'(busy), 0);
        chk("R1 pc", int'(pc), 0);
        chk("R1 coef", int'(coef), 0);
        chk("R1 delay base", int'(dly), 0);
        chk("R1 acc", int'(acc_en), 0);
        chk("R1 wr", int'(wr_en), 0);
        chk("R1 overrun", int'(overrun), 0);
        repeat (5) @(negedge clk);
        chk("R1 still idle", int'(busy), 0);
        chk("R1 pc parked", int'(pc), 0);

        // R2 R3 R5 passes 0..2, base 0 then wraps to 15 then 14
        for (int p = 0; p < 3; p++) begin
            pulse();
            run_pass(p, 1'b0, 1'b0);
            chk("R3 idle after end", int'(busy), 0);
            chk("R3 pc back at 0", int'(pc), 0);
            chk("R6 acc low idle", int'(acc_en), 0);
        end

        // R7 skip cancels instruction 3
        pulse();
        run_pass(3, 1'b1, 1'b0);
        chk("R7 pass length unchanged", int'(busy), 0);

        // R8 overrun: strobe mid-pass, next pass back to back
        pulse();
        run_pass(4, 1'b0, 1'b1);
        chk("R8 next pass started", int'(busy), 1);
        run_pass(5, 1'b0, 1'b0);
        chk("R8 idle after second pass", int'(busy), 0);
        chk("R8 overrun sticky", int'(overrun), 1);
        repeat (4) @(negedge clk);
        chk("R8 overrun still set", int'(overrun), 1);

        // R5 further passes: base continues from 10
        pulse();
        run_pass(6, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule